// File: doc/BRIEF.md
# Occupancy-Driven Directory Resize Controller

This controller sizes a set-associative coherence directory to its current load. It counts live directory entries: one more on every allocation, one fewer on every eviction. From that count and the current capacity (active sets times ways) it decides whether the directory should grow or shrink. The directory grows to twice as many sets when the count reaches four fifths of the capacity. It shrinks to half as many sets when the count falls to one fifth. The number of ways never changes.

A resize raises a stall that blocks directory access. The same stall asks the surrounding logic to move every stored entry to its new set. That logic reports completion on `move_done`. Only then does the controller switch to the new set-index mask and the new partition power enables, and release the stall. The index mask picks the low address bits used as the set index. Stored tags are sized for the smallest configuration, so at larger sizes some low tag bits are redundant with the index.

The entry count is kept across a resize, and both thresholds follow the new capacity. The active set count stays between a minimum and a maximum power of two.

Top module: `dir_resize_ctrl`

## Requirements
- R1: `occ` rises by one the edge after a cycle with `alloc` high and `evict` low, and falls by one after `evict` high with `alloc` low. It does not rise above WAYS<<MAX_LOG and does not fall below zero.
- R2: A cycle with both `alloc` and `evict` high leaves `occ` unchanged.
- R3: If `stall` is low, `size_log2` is below MAX_LOG and 5*`occ` >= 4*(WAYS<<`size_log2`), then `stall` is high after the next edge and `tgt_log2` = `size_log2`+1.
- R4: If `stall` is low, `size_log2` is above MIN_LOG and 5*`occ` <= (WAYS<<`size_log2`), then `stall` is high after the next edge and `tgt_log2` = `size_log2`-1.
- R5: No resize is started past the bounds. At MAX_LOG a full directory raises no stall, and at MIN_LOG an empty one raises none. `size_log2` always lies in [MIN_LOG, MAX_LOG].
- R6: While `stall` is high and `move_done` is low, `stall`, `size_log2`, `idx_mask` and `pwr_en` hold. `move_done` while `stall` is low has no effect.
- R7: `move_done` high while `stall` is high makes `stall` low after that edge, with `size_log2` equal to the prior `tgt_log2`. `occ` is not reset by a resize.
- R8: Bit i of `idx_mask` is 1 exactly when i < `size_log2`.
- R9: Bit p of `pwr_en` is 1 exactly when p < 2^(`size_log2`-MIN_LOG). Each partition holds 2^MIN_LOG sets.
- R10: During and right after reset, `occ`=0, `size_log2`=`tgt_log2`=MIN_LOG and `stall`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc | input | 1 | A directory entry was allocated this cycle |
| evict | input | 1 | A directory entry was evicted this cycle |
| move_done | input | 1 | Entry migration for the pending resize is finished |
| occ | output | $clog2((WAYS<<MAX_LOG)+1) | Live entry count |
| size_log2 | output | $clog2(MAX_LOG+1) | Log2 of the active set count |
| tgt_log2 | output | $clog2(MAX_LOG+1) | Log2 of the set count being moved to (equals size_log2 when idle) |
| idx_mask | output | MAX_LOG | Set-index bit mask |
| pwr_en | output | 2^(MAX_LOG-MIN_LOG) | Power enable per set partition |
| stall | output | 1 | Directory access blocked, migration requested |

## Verification
Each result has a fixed latency. `occ` changes one edge after the `alloc`/`evict` cycle. `stall` rises one edge after the cycle whose registered count crosses a threshold, which is two edges after the crossing allocation. `size_log2`, `idx_mask` and `pwr_en` change on the same edge that samples `move_done`. The bench keeps a reference model that advances on each rising edge. It compares all outputs on the falling edge and drives new inputs right after. Every comparison therefore sees exactly the latency above.

// File: rtl/dir_resize_ctrl.sv
module dir_resize_ctrl #(
  parameter int WAYS    = 4,
  parameter int MIN_LOG = 2,
  parameter int MAX_LOG = 5,
  localparam int OCC_MAX = WAYS << MAX_LOG,
  localparam int OW      = $clog2(OCC_MAX + 1),
  localparam int LW      = $clog2(MAX_LOG + 1),
  localparam int NPART   = 1 << (MAX_LOG - MIN_LOG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc,
  input  logic               evict,
  input  logic               move_done,
  output logic [OW-1:0]      occ,
  output logic [LW-1:0]      size_log2,
  output logic [LW-1:0]      tgt_log2,
  output logic [MAX_LOG-1:0] idx_mask,
  output logic [NPART-1:0]   pwr_en,
  output logic               stall
);
  localparam logic [OW-1:0] OCC_TOP = OW'(OCC_MAX);
  localparam logic [LW-1:0] LVL_MIN = LW'(MIN_LOG);
  localparam logic [LW-1:0] LVL_MAX = LW'(MAX_LOG);

  logic [31:0] occ5, cap;
  logic        grow, shrink;

  assign occ5   = 32'(occ) * 32'd5;
  assign cap    = 32'(WAYS) << size_log2;
  assign grow   = (size_log2 < LVL_MAX) && (occ5 >= (cap << 2));
  assign shrink = (size_log2 > LVL_MIN) && (occ5 <= cap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else if (alloc && !evict && occ != OCC_TOP) occ <= occ + 1'b1;
    else if (evict && !alloc && occ != '0) occ <= occ - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall     <= 1'b0;
      size_log2 <= LVL_MIN;
      tgt_log2  <= LVL_MIN;
    end else if (!stall) begin
      if (grow) begin
        stall    <= 1'b1;
        tgt_log2 <= size_log2 + 1'b1;
      end else if (shrink) begin
        stall    <= 1'b1;
        tgt_log2 <= size_log2 - 1'b1;
      end
    end else if (move_done) begin
      stall     <= 1'b0;
      size_log2 <= tgt_log2;
    end
  end

  always_comb begin
    for (int i = 0; i < MAX_LOG; i++) idx_mask[i] = (i < int'(size_log2));
    for (int p = 0; p < NPART; p++)   pwr_en[p]   = (p < (1 << (int'(size_log2) - MIN_LOG)));
  end

  AST_OCC_CAP:     assert property (@(posedge clk) disable iff (!rst_n) occ <= OCC_TOP); // R1
  AST_BOTH_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (alloc && evict) |=> $stable(occ)); // R2
  AST_STEP_ONE:    assert property (@(posedge clk) disable iff (!rst_n) $rose(stall) |-> (tgt_log2 == size_log2 + 1'b1 || tgt_log2 + 1'b1 == size_log2)); // R3
  AST_SIZE_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) size_log2 >= LVL_MIN && size_log2 <= LVL_MAX); // R5
  AST_STALL_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (stall && !move_done) |=> (stall && $stable(size_log2) && $stable(pwr_en) && $stable(idx_mask))); // R6
  AST_ACK_APPLY:   assert property (@(posedge clk) disable iff (!rst_n) (stall && move_done) |=> (!stall && size_log2 == $past(tgt_log2))); // R7
endmodule

// File: tb/dir_resize_ctrl_bench.sv
module dir_resize_ctrl_bench;
  localparam int WAYS = 4, MIN_LOG = 2, MAX_LOG = 5;
  localparam int OMAX = WAYS << MAX_LOG;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc = 1'b0, evict = 1'b0, move_done = 1'b0;
  logic [7:0] occ;
  logic [2:0] size_log2, tgt_log2;
  logic [4:0] idx_mask;
  logic [7:0] pwr_en;
  logic       stall;

  int checks = 0, fails = 0;
  int m_occ, m_lvl, m_tgt, m_stall;
  bit done_flag = 0;

  always #4 clk = ~clk;

  dir_resize_ctrl #(.WAYS(WAYS), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG)) u_dir_resize_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .evict(evict), .move_done(move_done),
    .occ(occ), .size_log2(size_log2), .tgt_log2(tgt_log2), .idx_mask(idx_mask),
    .pwr_en(pwr_en), .stall(stall));

  function automatic int exp_mask(int l);
    return (1 << l) - 1;
  endfunction

  function automatic int exp_pwr(int l);
    return (1 << (1 << (l - MIN_LOG))) - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_occ <= 0; m_lvl <= MIN_LOG; m_tgt <= MIN_LOG; m_stall <= 0;
    end else begin
      if (alloc && !evict && m_occ < OMAX) m_occ <= m_occ + 1;
      else if (evict && !alloc && m_occ > 0) m_occ <= m_occ - 1;
      if (m_stall == 0) begin
        if (m_lvl < MAX_LOG && m_occ * 5 >= 4 * (WAYS << m_lvl)) begin
          m_stall <= 1; m_tgt <= m_lvl + 1;
        end else if (m_lvl > MIN_LOG && m_occ * 5 <= (WAYS << m_lvl)) begin
          m_stall <= 1; m_tgt <= m_lvl - 1;
        end
      end else if (move_done) begin
        m_stall <= 0; m_lvl <= m_tgt;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R1 occ", int'(occ), m_occ);
    check("R6 stall", int'(stall), m_stall);
    check("R7 size", int'(size_log2), m_lvl);
    check(m_tgt > m_lvl ? "R3 target" : "R4 target", int'(tgt_log2), m_tgt);
    check("R8 mask", int'(idx_mask), exp_mask(m_lvl));
    check("R9 power", int'(pwr_en), exp_pwr(m_lvl));
  endtask

  task automatic step(bit a, bit e, bit d);
    @(negedge clk);
    compare_all();
    alloc = a; evict = e; move_done = d;
  endtask

  task automatic run_phase(int n, int pa, int pe, int pd);
    for (int k = 0; k < n; k++)
      step(($urandom % 100) < pa, ($urandom % 100) < pe, ($urandom % 100) < pd);
  endtask

  initial begin
    void'($urandom(32'd7421));
    repeat (3) @(negedge clk);
    check("R10 occ", int'(occ), 0);
    check("R10 size", int'(size_log2), MIN_LOG);
    check("R10 target", int'(tgt_log2), MIN_LOG);
    check("R10 stall", int'(stall), 0);
    rst_n = 1'b1;
    step(0, 0, 0);
    check("R10 occ after release", int'(occ), 0);

    step(0, 1, 1); step(0, 0, 0);
    check("R1 no underflow", int'(occ), 0);
    check("R5 no shrink at min", int'(stall), 0);

    repeat (5) step(1, 0, 0);
    step(1, 1, 0); step(1, 1, 1); step(0, 0, 0);
    check("R2 both hold", int'(occ), 5);

    repeat (10) step(1, 0, 0);
    repeat (3) step(0, 0, 0);
    check("R3 stall held", int'(stall), 1);
    repeat (4) step(0, 0, 0);
    check("R6 stall waits for ack", int'(stall), 1);
    step(0, 0, 1); step(0, 0, 0);
    check("R7 size after ack", int'(size_log2), MIN_LOG + 1);
    check("R7 occ kept", int'(occ), 15);

    run_phase(600, 75, 20, 40);
    repeat (300) step(1, 0, 1);
    step(0, 0, 0); step(0, 0, 0);
    check("R5 max size", int'(size_log2), MAX_LOG);
    check("R5 no grow at max", int'(stall), 0);
    check("R1 saturate top", int'(occ), OMAX);

    run_phase(600, 20, 75, 40);
    repeat (300) step(0, 1, 1);
    step(0, 0, 0); step(0, 0, 0);
    check("R5 min size", int'(size_log2), MIN_LOG);
    check("R4 shrunk empty", int'(occ), 0);

    for (int r = 0; r < 6; r++) begin
      run_phase(400, 70, 25, 15);
      run_phase(400, 25, 70, 15);
    end
    run_phase(300, 50, 50, 50);
    step(0, 0, 0);
    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule